// File: doc/BRIEF.md
# Low-Speed USB Packet Serializer

This block sends one packet onto a low-speed USB differential pair. A client fills a byte store and pulses a start strobe with the number of payload bytes. The serializer then drives the pair to the idle J level with its drivers switched on and sends the synchronization byte. It reads each payload byte in turn through a simple address/data read port. It encodes every bit with NRZI and inserts a stuffing transition after each run of six ones. It closes with an end-of-packet, drives one bit time of J and then switches the drivers off.

A handshake reply is a one-byte payload. A data packet is any longer buffer, with its checksum already placed in the store by the client. Every bit slot lasts a fixed number of clock cycles, set by a parameter (default 8, for a 12 MHz clock at the 1.5 Mbit/s line rate). While the serializer is busy it takes no new request.

Top module: `ls_usb_tx`

## Requirements
- R1: After reset and whenever no packet is in flight, outEnable, busy and done are low and the lines rest at J (dPlus=0, dMinus=1).
- R2: A start accepted while idle is followed at once by one bit slot of J (dPlus=0, dMinus=1) with outEnable high, before the first synchronization bit.
- R3: Every bit slot, including stuffing, end-of-packet and J slots, lasts exactly CYC_PER_BIT clock cycles (default 8), and the lines do not change within a slot.
- R4: The synchronization byte 8'h80 goes out first, least significant bit first. It is followed by byteCount bytes read from rdAddr 0, 1, 2, ... in ascending order, each least significant bit first.
- R5: NRZI: a 0 bit inverts the line state and a 1 bit keeps it, where K is dPlus=1, dMinus=0 and J is dPlus=0, dMinus=1. The first synchronization bit therefore moves the lines from J to K. dPlus and dMinus are never both high.
- R6: After six consecutive 1 bits, one extra inverting slot is inserted. The run of ones carries across byte boundaries, including from the synchronization byte into the first payload byte. A run that reaches six on the final bit still gets its extra slot before end-of-packet.
- R7: After the last bit (or stuffing) slot, both lines are low for two bit slots, then J is driven for one slot, then outEnable drops.
- R8: done is high for exactly one cycle: the first cycle with outEnable low after a packet. busy is high from the cycle after start is accepted through the last J cycle.
- R9: A start pulse while busy is ignored: the packet in flight is unchanged and no second packet follows.
- R10: byteCount=0 sends only the synchronization byte; byteCount=1 sends a single-byte handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CYC_PER_BIT cycles per bit |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a packet, sampled while idle |
| byteCount | input | CNT_W | Payload bytes after the synchronization byte, sampled with start |
| rdAddr | output | CNT_W | Index of the payload byte wanted next |
| rdData | input | 8 | Payload byte at rdAddr, valid in the same cycle |
| dPlus | output | 1 | Positive line level |
| dMinus | output | 1 | Negative line level |
| outEnable | output | 1 | Line driver enable |
| busy | output | 1 | Packet in flight |
| done | output | 1 | One-cycle pulse after the lines are released |

## Verification
The payloads were picked so that the run-of-ones counter is tested at each place it can wrongly reset or miss. 8'h1F needs stuffing that only the synchronization byte's final 1 makes due. 8'hE0 followed by 8'h07 makes a run split across two payload bytes. 8'hFC ends the packet on a sixth 1, so a stuffing slot must come before end-of-packet. 8'hFF pairs give repeated stuffing inside long runs. Zero and one byte counts check the length handling. A start pulse in mid-packet checks that the packet in flight is unchanged and that nothing follows it.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_PATTERN = 8'h80;
  localparam int STUFF_RUN = 6;

  typedef enum logic [1:0] {
    LM_IDLE,
    LM_J,
    LM_DATA,
    LM_SE0
  } lineMode_e;

  typedef struct packed {
    logic      loadSync;
    logic      emitBit;
    lineMode_e mode;
  } ctrlStrobes_t;
endpackage

// File: rtl/usbtx_ctrl.sv
module usbtx_ctrl
  import usbtx_pkg::*;
#(
  parameter int CYC_PER_BIT = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         finished,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  localparam int TW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(CYC_PER_BIT - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_EOP1,
    ST_EOP2,
    ST_TRAIL
  } state_e;

  state_e        state;
  logic [TW-1:0] timer;
  logic          slotEnd;
  logic          accept;

  assign slotEnd = (timer == LAST_TICK);
  assign accept  = (state == ST_IDLE) && start;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    strobes.loadSync = accept;
    strobes.emitBit  = slotEnd && ((state == ST_LEAD) ||
                                   ((state == ST_DATA) && !finished));
    unique case (state)
      ST_IDLE:           strobes.mode = LM_IDLE;
      ST_LEAD, ST_TRAIL: strobes.mode = LM_J;
      ST_DATA:           strobes.mode = LM_DATA;
      default:           strobes.mode = LM_SE0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) timer <= '0;
      else timer <= slotEnd ? '0 : timer + 1'b1;
      unique case (state)
        ST_IDLE:  if (accept) state <= ST_LEAD;
        ST_LEAD:  if (slotEnd) state <= ST_DATA;
        ST_DATA:  if (slotEnd && finished) state <= ST_EOP1;
        ST_EOP1:  if (slotEnd) state <= ST_EOP2;
        ST_EOP2:  if (slotEnd) state <= ST_TRAIL;
        ST_TRAIL: if (slotEnd) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usbtx_datapath.sv
module usbtx_datapath
  import usbtx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [BYTE_W-1:0] rdData,
  output logic [CNT_W-1:0]  rdAddr,
  output logic              finished,
  output logic              dPlus,
  output logic              dMinus,
  output logic              outEnable
);
  localparam int IW = $clog2(BYTE_W);
  localparam logic [IW-1:0] LAST_BIT = IW'(BYTE_W - 1);
  localparam logic [2:0] RUN_LIMIT = 3'(STUFF_RUN);

  logic [BYTE_W-1:0] shReg;
  logic [IW-1:0]     bitIdx;
  logic [CNT_W-1:0]  remaining;
  logic [2:0]        onesRun;
  logic              levelK;
  logic              noMore;
  logic              stuffDue;

  assign stuffDue = (onesRun == RUN_LIMIT);
  assign finished = noMore && !stuffDue;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      bitIdx    <= '0;
      remaining <= '0;
      rdAddr    <= '0;
      onesRun   <= '0;
      levelK    <= 1'b0;
      noMore    <= 1'b0;
    end else if (strobes.loadSync) begin
      shReg     <= SYNC_PATTERN;
      bitIdx    <= '0;
      remaining <= byteCount;
      rdAddr    <= '0;
      onesRun   <= '0;
      levelK    <= 1'b0;
      noMore    <= 1'b0;
    end else if (strobes.emitBit) begin
      if (stuffDue) begin
        levelK  <= !levelK;
        onesRun <= '0;
      end else begin
        if (shReg[0]) onesRun <= onesRun + 3'd1;
        else begin
          levelK  <= !levelK;
          onesRun <= '0;
        end
        if (bitIdx == LAST_BIT) begin
          bitIdx <= '0;
          if (remaining == '0) noMore <= 1'b1;
          else begin
            shReg     <= rdData;
            rdAddr    <= rdAddr + 1'b1;
            remaining <= remaining - 1'b1;
          end
        end else begin
          bitIdx <= bitIdx + 1'b1;
          shReg  <= shReg >> 1;
        end
      end
    end
  end

  always_comb begin
    unique case (strobes.mode)
      LM_IDLE: begin outEnable = 1'b0; dPlus = 1'b0;   dMinus = 1'b1;    end
      LM_J:    begin outEnable = 1'b1; dPlus = 1'b0;   dMinus = 1'b1;    end
      LM_DATA: begin outEnable = 1'b1; dPlus = levelK; dMinus = !levelK; end
      default: begin outEnable = 1'b1; dPlus = 1'b0;   dMinus = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/ls_usb_tx.sv
module ls_usb_tx
  import usbtx_pkg::*;
#(
  parameter int CYC_PER_BIT = 8,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  byteCount,
  output logic [CNT_W-1:0]  rdAddr,
  input  logic [7:0]        rdData,
  output logic              dPlus,
  output logic              dMinus,
  output logic              outEnable,
  output logic              busy,
  output logic              done
);
  ctrlStrobes_t strobes;
  logic         finished;

  usbtx_ctrl #(.CYC_PER_BIT(CYC_PER_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .finished(finished),
    .strobes(strobes), .busy(busy), .done(done)
  );

  usbtx_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteCount(byteCount),
    .rdData(rdData), .rdAddr(rdAddr), .finished(finished),
    .dPlus(dPlus), .dMinus(dMinus), .outEnable(outEnable)
  );
endmodule

// File: rtl/usbtx_checks.sv
module usbtx_checks (
  input logic clk,
  input logic rstN,
  input logic dPlus,
  input logic dMinus,
  input logic outEnable,
  input logic busy,
  input logic done
);
  // R1: drivers are off whenever no packet is in flight
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outEnable);

  // R5: the lines never show both levels high
  p_no_se1_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(dPlus && dMinus));

  // R2: drivers switch on into J
  p_lead_is_j_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEnable) |-> (!dPlus && dMinus));

  // R7: the last driven slot before release is J
  p_release_from_j_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outEnable) |-> ($past(!dPlus) && $past(dMinus)));

  // R8: done is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done marks the end of busy
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy));

  // R9: busy never drops without a done pulse
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));
endmodule

bind ls_usb_tx usbtx_checks u_chk (
  .clk(clk), .rstN(rstN), .dPlus(dPlus), .dMinus(dMinus),
  .outEnable(outEnable), .busy(busy), .done(done)
);

// File: tb/tb_ls_usb_tx.sv
module tb_ls_usb_tx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] byteCount = '0;
  logic [7:0] rdAddr;
  logic [7:0] rdData;
  logic       dPlus, dMinus, outEnable, busy, done;

  logic [7:0] mem [0:15];
  int total = 0;
  int bad = 0;

  bit    eDp [0:511];
  bit    eDm [0:511];
  string eTag [0:511];
  int    nS;

  always #2 clk = !clk;

  assign rdData = mem[rdAddr[3:0]];

  ls_usb_tx dut (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .rdAddr(rdAddr), .rdData(rdData), .dPlus(dPlus), .dMinus(dMinus),
    .outEnable(outEnable), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [3:0] act,
                       input logic [3:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual{oe,busy,dp,dm}=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic addSlot(input bit dp, input bit dm, input string tag);
    eDp[nS] = dp;
    eDm[nS] = dm;
    eTag[nS] = tag;
    nS++;
  endtask

  // expected line sequence from the requirements (R2, R4, R5, R6, R7)
  task automatic buildExpected(input int cnt);
    bit lvl = 1'b0;
    int ones = 0;
    nS = 0;
    addSlot(1'b0, 1'b1, "R2 lead J");
    for (int i = 0; i <= 8 * cnt + 7; i++) begin
      bit b;
      if (i < 8) b = (8'h80 >> i) & 1'b1;
      else b = (mem[(i - 8) / 8] >> ((i - 8) % 8)) & 1'b1;
      if (ones == 6) begin
        lvl = !lvl; ones = 0;
        addSlot(lvl, !lvl, "R6 stuff slot");
      end
      if (b) ones++;
      else begin lvl = !lvl; ones = 0; end
      addSlot(lvl, !lvl, (i < 8) ? "R4 R5 sync bit" : "R4 R5 data bit");
    end
    if (ones == 6) begin
      lvl = !lvl;
      addSlot(lvl, !lvl, "R6 final stuff slot");
    end
    addSlot(1'b0, 1'b0, "R7 SE0 first");
    addSlot(1'b0, 1'b0, "R7 SE0 second");
    addSlot(1'b0, 1'b1, "R7 trailing J");
  endtask

  task automatic runPacket(input int cnt, input string name, input bit poke);
    buildExpected(cnt);
    @(negedge clk);
    start = 1'b1;
    byteCount = 8'(cnt);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc <= 8 * nS; cyc++) begin
      if ((cyc % 8 == 4) && (cyc / 8 < nS)) begin
        int s = cyc / 8;
        check({outEnable, busy, dPlus, dMinus} == {2'b11, eDp[s], eDm[s]},
              $sformatf("%s slot %0d %s R3", name, s, eTag[s]),
              {outEnable, busy, dPlus, dMinus}, {2'b11, eDp[s], eDm[s]});
      end
      if (poke && cyc == 20) begin start = 1'b1; byteCount = 8'd3; end
      if (poke && cyc == 21) start = 1'b0;
      if (cyc == 8 * nS - 1)
        check(busy && !done, {name, " R8 busy before end"},
              {outEnable, busy, dPlus, dMinus}, 4'b1101);
      if (cyc == 8 * nS)
        check(done && !busy && !outEnable, {name, " R8 done pulse R7 release"},
              {outEnable, done, busy, 1'b0}, 4'b0100);
      if (cyc < 8 * nS) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(!busy && !outEnable && !done && !dPlus && dMinus,
          {name, " R1 R9 stays idle"},
          {outEnable, busy, dPlus, dMinus}, 4'b0001);
  endtask

  task automatic testReset;
    check({outEnable, busy, done, dPlus, dMinus} == 5'b00001, "R1 reset state",
          {outEnable, busy, dPlus, dMinus}, 4'b0001);
  endtask

  task automatic testHandshake;
    mem[0] = 8'hD2;
    runPacket(1, "R10 handshake", 1'b0);
  endtask

  task automatic testSyncOnly;
    runPacket(0, "R10 sync only", 1'b0);
  endtask

  task automatic testSyncCarry;
    mem[0] = 8'h1F;
    runPacket(1, "R6 carry from sync", 1'b0);
  endtask

  task automatic testFinalStuff;
    mem[0] = 8'hFC;
    runPacket(1, "R6 stuff before EOP", 1'b0);
  endtask

  task automatic testMixed;
    mem[0] = 8'h00; mem[1] = 8'hE0; mem[2] = 8'h07;
    mem[3] = 8'hA5; mem[4] = 8'hFF; mem[5] = 8'hFF;
    runPacket(6, "R4 R6 mixed bytes", 1'b0);
  endtask

  task automatic testBusyStart;
    mem[0] = 8'h3C; mem[1] = 8'h81;
    runPacket(2, "R9 start while busy", 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHandshake();
    testSyncOnly();
    testSyncCarry();
    testFinalStuff();
    testMixed();
    testBusyStart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule